// File: doc/BRIEF.md
# Repeating Block Memory Mover

This block copies a run of bytes from one place in a byte-wide memory to another, one byte per step, under a 16-bit byte count. It serves as the data-movement engine behind a processor's block-copy instructions. A start strobe loads a source pointer, a destination pointer, a count and a mode. The engine then reads one byte at the source, writes it to the destination, decrements the count and moves each pointer as its own stepping mode selects.

Each pointer can count up, count down or stay fixed, independently of the other. A fixed pointer suits a copy to or from a single port address. In single-shot mode the engine does one step and stops. In auto-repeat mode it keeps stepping until the count has been decremented to zero, so a starting count of zero gives a full 65536-byte pass. Every memory access holds its request until the memory answers with ready. After each step the engine updates a parity/overflow flag, a subtract flag and a half-carry flag in the way those instructions define.

Top module: `blkmove_engine`

## Requirements
- R1: A start pulse while the engine is idle loads the source, destination and count inputs into src_ptr, dst_ptr and count on the next clock edge. A start pulse while busy is high has no effect.
- R2: Each step first raises mem_rd with mem_addr equal to src_ptr. After the read is accepted it raises mem_wr with mem_addr equal to dst_ptr and mem_wdata equal to the byte read. mem_rd and mem_wr are never high together.
- R3: Each pointer has its own 2-bit mode: 2'b01 adds one, 2'b10 subtracts one, and 2'b00 or 2'b11 holds the pointer. The pointer moves when the write of a step is accepted. Addresses wrap modulo 65536.
- R4: count decreases by one, modulo 65536, each time a write is accepted.
- R5: With repeat_en high at start, steps continue until count reaches zero after a decrement. A starting count of zero gives 65536 steps.
- R6: With repeat_en low at start, exactly one step is made, whatever the count.
- R7: Each accepted write clears flag_n and flag_h. In repeat mode it clears flag_pv. In single-shot mode flag_pv is set exactly when count is non-zero after the step.
- R8: busy is high from the cycle after an accepted start until the final write is accepted. done is high for exactly the one cycle after the final write is accepted.
- R9: After reset the engine is idle: all pointer, count and flag outputs are zero and mem_rd, mem_wr, busy and done are low.
- R10: While mem_rdy is low, a pending read or write keeps its strobe, address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start strobe, sampled while idle |
| repeat_en | input | 1 | 1 selects auto-repeat, 0 selects single-shot |
| src_mode | input | 2 | Source stepping: 01 up, 10 down, 00/11 fixed |
| dst_mode | input | 2 | Destination stepping: 01 up, 10 down, 00/11 fixed |
| src_init | input | 16 | Starting source address |
| dst_init | input | 16 | Starting destination address |
| cnt_init | input | 16 | Starting byte count (0 means 65536) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_rdy during a read |
| mem_rdy | input | 1 | Memory accepts the current access |
| src_ptr | output | 16 | Current source address |
| dst_ptr | output | 16 | Current destination address |
| count | output | 16 | Remaining byte count |
| flag_pv | output | 1 | Parity/overflow flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final step |

## Verification
The hardest case to reach from the ports is the wrap of a zero starting count in repeat mode. The engine must then run through all 65536 steps and stop only when the count returns to zero. The bench reaches it with a single full pass under an always-ready memory and counts every accepted write. Stalls are reached by driving mem_rdy from a pseudo-random sequence. A behavioural model then follows the request and pointer outputs on every cycle of the wait. A start pulse is also driven into the middle of a running transfer, with different operands, to show that it is ignored.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic [1:0] {
    BM_IDLE = 2'b00,
    BM_RD   = 2'b01,
    BM_WR   = 2'b10
  } bm_state_e;

  localparam logic [1:0] BM_DIR_UP   = 2'b01;
  localparam logic [1:0] BM_DIR_DOWN = 2'b10;
endpackage

// File: rtl/blkmove_stepper.sv
module blkmove_stepper #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic [1:0]   dir,
  output logic [W-1:0] val
);
  import blkmove_pkg::*;

  logic [W-1:0] val_d;

  always_comb begin
    val_d = val;
    if (load) begin
      val_d = load_val;
    end else if (adv) begin
      case (dir)
        BM_DIR_UP:   val_d = val + {{(W-1){1'b0}}, 1'b1};
        BM_DIR_DOWN: val_d = val - {{(W-1){1'b0}}, 1'b1};
        default:     val_d = val;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= val_d;
  end

  // R3
  ptr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && dir == BM_DIR_UP) |=> val == $past(val) + {{(W-1){1'b0}}, 1'b1});
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && (dir == 2'b00 || dir == 2'b11)) |=> $stable(val));
endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rep,
  input  logic rdy,
  input  logic last_byte,
  output logic rd_act,
  output logic wr_act,
  output logic load,
  output logic step,
  output logic done,
  output logic busy
);
  import blkmove_pkg::*;

  bm_state_e state_q, state_d;
  logic      done_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      BM_IDLE: if (start) begin
        load    = 1'b1;
        state_d = BM_RD;
      end
      BM_RD: if (rdy) state_d = BM_WR;
      BM_WR: if (rdy) begin
        step = 1'b1;
        if (rep && !last_byte) begin
          state_d = BM_RD;
        end else begin
          state_d = BM_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = BM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BM_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign rd_act = (state_q == BM_RD);
  assign wr_act = (state_q == BM_WR);
  assign busy   = (state_q != BM_IDLE);

  // R10
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !rdy) |=> rd_act);
  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rdy) |=> wr_act);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rep) |=> (!busy && done));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          repeat_en,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count,
  output logic          flag_pv,
  output logic          flag_n,
  output logic          flag_h,
  output logic          busy,
  output logic          done
);
  localparam int NPTR = 2;
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [1:0]    rst_sync;
  logic          rst_s;
  logic          load, step, rd_act, wr_act, last_byte;
  logic          rep_q, rep_d;
  logic [1:0]    sm_q, sm_d, dm_q, dm_d;
  logic [DW-1:0] data_q, data_d;
  logic [CW-1:0] cnt_d, cnt_after;
  logic          pv_d, n_d, h_d;
  logic [AW-1:0] ptr_init [NPTR];
  logic [1:0]    ptr_dir  [NPTR];
  logic [AW-1:0] ptr_val  [NPTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  blkmove_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .start     (start),
    .rep       (rep_q),
    .rdy       (mem_rdy),
    .last_byte (last_byte),
    .rd_act    (rd_act),
    .wr_act    (wr_act),
    .load      (load),
    .step      (step),
    .done      (done),
    .busy      (busy)
  );

  assign ptr_init[0] = src_init;
  assign ptr_init[1] = dst_init;
  assign ptr_dir[0]  = sm_q;
  assign ptr_dir[1]  = dm_q;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    blkmove_stepper #(.W(AW)) u_step (
      .clk      (clk),
      .rst_n    (rst_s),
      .load     (load),
      .load_val (ptr_init[g]),
      .adv      (step),
      .dir      (ptr_dir[g]),
      .val      (ptr_val[g])
    );
  end

  assign src_ptr   = ptr_val[0];
  assign dst_ptr   = ptr_val[1];
  assign cnt_after = count - CNT_ONE;
  assign last_byte = (count == CNT_ONE);

  always_comb begin
    rep_d  = rep_q;
    sm_d   = sm_q;
    dm_d   = dm_q;
    cnt_d  = count;
    data_d = data_q;
    pv_d   = flag_pv;
    n_d    = flag_n;
    h_d    = flag_h;
    if (load) begin
      rep_d = repeat_en;
      sm_d  = src_mode;
      dm_d  = dst_mode;
      cnt_d = cnt_init;
    end
    if (rd_act && mem_rdy) data_d = mem_rdata;
    if (step) begin
      cnt_d = cnt_after;
      n_d   = 1'b0;
      h_d   = 1'b0;
      pv_d  = !rep_q && (cnt_after != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rep_q   <= 1'b0;
      sm_q    <= 2'b00;
      dm_q    <= 2'b00;
      count   <= '0;
      data_q  <= '0;
      flag_pv <= 1'b0;
      flag_n  <= 1'b0;
      flag_h  <= 1'b0;
    end else begin
      rep_q   <= rep_d;
      sm_q    <= sm_d;
      dm_q    <= dm_d;
      count   <= cnt_d;
      data_q  <= data_d;
      flag_pv <= pv_d;
      flag_n  <= n_d;
      flag_h  <= h_d;
    end
  end

  assign mem_rd    = rd_act;
  assign mem_wr    = wr_act;
  assign mem_addr  = wr_act ? dst_ptr : src_ptr;
  assign mem_wdata = data_q;

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_wr && mem_rdy) |=> count == $past(count) - CNT_ONE);
  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_wr && mem_rdy) |=> (!flag_n && !flag_h));
  // R10
  wr_wait_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
  // R1
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start && !mem_rdy) |=> ($stable(count) && $stable(src_ptr) && $stable(dst_ptr)));
endmodule

// File: tb/blkmove_engine_tb_top.sv
module blkmove_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        repeat_en = 1'b0;
  logic [1:0]  src_mode = 2'b00, dst_mode = 2'b00;
  logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rdy = 1'b0;
  logic [15:0] src_ptr, dst_ptr, count;
  logic        flag_pv, flag_n, flag_h, busy, done;

  always #10 clk = ~clk;

  blkmove_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .repeat_en(repeat_en),
    .src_mode(src_mode), .dst_mode(dst_mode), .src_init(src_init),
    .dst_init(dst_init), .cnt_init(cnt_init), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count),
    .flag_pv(flag_pv), .flag_n(flag_n), .flag_h(flag_h), .busy(busy), .done(done)
  );

  int n_tests = 0, n_fail = 0, cyc = 0, writes = 0;
  bit chk_en = 0, rdy_rand = 0, prev_rdy = 1;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] bmem [int];

  int m_ph = 0;
  logic [15:0] m_src = 0, m_dst = 0, m_cnt = 0;
  logic [7:0] m_data = 0;
  logic [1:0] m_sd = 0, m_dd = 0;
  bit m_rep = 0, m_pv = 0, m_n = 0, m_h = 0, m_done = 0;

  function automatic logic [7:0] rd_byte(logic [15:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return 8'((int'(a) * 7 + 3) & 255);
  endfunction

  function automatic logic [15:0] stepv(logic [15:0] v, logic [1:0] d);
    if (d == 2'b01) return v + 16'd1;
    if (d == 2'b10) return v - 16'd1;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_data = 0;
      m_pv = 0; m_n = 0; m_h = 0; m_done = 0; m_rep = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (start) begin
          m_src = src_init; m_dst = dst_init; m_cnt = cnt_init;
          m_rep = repeat_en; m_sd = src_mode; m_dd = dst_mode; m_ph = 1;
        end
        1: if (mem_rdy) begin m_data = rd_byte(m_src); m_ph = 2; end
        default: if (mem_rdy) begin
          bmem[int'(m_dst)] = m_data;
          writes++;
          m_src = stepv(m_src, m_sd);
          m_dst = stepv(m_dst, m_dd);
          m_cnt = m_cnt - 16'd1;
          m_n = 0; m_h = 0;
          m_pv = !m_rep && (m_cnt != 0);
          if (m_rep && m_cnt != 0) m_ph = 1;
          else begin m_ph = 0; m_done = 1; end
        end
      endcase
    end
  end

  // compare on every falling edge, then drive the memory side
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      finish_run();
    end
    if (chk_en) begin
      check("R2 rd", mem_rd, m_ph == 1);
      check("R2 wr", mem_wr, m_ph == 2);
      if (m_ph == 1) check(prev_rdy ? "R2 rd addr" : "R10 rd addr", mem_addr, m_src);
      if (m_ph == 2) begin
        check(prev_rdy ? "R2 wr addr" : "R10 wr addr", mem_addr, m_dst);
        check(prev_rdy ? "R2 wdata" : "R10 wdata", mem_wdata, m_data);
      end
      check("R3 src", src_ptr, m_src);
      check("R3 dst", dst_ptr, m_dst);
      check("R4 count", count, m_cnt);
      check("R7 flags", {flag_pv, flag_n, flag_h}, {m_pv, m_n, m_h});
      check("R8 busy", busy, m_ph != 0);
      check("R8 done", done, m_done);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    prev_rdy = rdy_rand ? lfsr[0] : 1'b1;
    mem_rdy <= prev_rdy;
    mem_rdata <= rd_byte(mem_addr);
  end

  task automatic run_xfer(bit rep, logic [1:0] sm, logic [1:0] dm,
                          logic [15:0] s, logic [15:0] d, logic [15:0] c,
                          bit rnd, bit poke, int exp_steps);
    int w0;
    @(negedge clk);
    rdy_rand = rnd;
    w0 = writes;
    repeat_en = rep; src_mode = sm; dst_mode = dm;
    src_init = s; dst_init = d; cnt_init = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: operands visible after the start edge
    check("R1 load", {src_ptr, dst_ptr}, {s, d});
    if (poke) begin
      @(negedge clk);
      repeat_en = 0; src_init = 16'h5555; dst_init = 16'h6666; cnt_init = 16'h0077;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!m_done) @(negedge clk);
    check(rep ? "R5 steps" : "R6 steps", writes - w0, exp_steps);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset", {mem_rd, mem_wr, busy, done, flag_pv, flag_n, flag_h}, 0);
    check("R9 ptrs", {src_ptr, dst_ptr, count}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1;
    run_xfer(0, 2'b01, 2'b01, 16'h1000, 16'h2000, 16'd3, 0, 0, 1);   // R6 R7 pv=1
    run_xfer(0, 2'b10, 2'b10, 16'h1000, 16'h2000, 16'd1, 1, 0, 1);   // R7 pv=0
    run_xfer(1, 2'b01, 2'b01, 16'h1100, 16'h3000, 16'd5, 1, 0, 5);   // R5
    run_xfer(1, 2'b10, 2'b10, 16'h0002, 16'h0001, 16'd4, 1, 0, 4);   // R3 wrap
    run_xfer(1, 2'b01, 2'b00, 16'h1200, 16'h4000, 16'd3, 1, 0, 3);   // R3 dst fixed
    run_xfer(1, 2'b10, 2'b11, 16'h1300, 16'h4001, 16'd3, 0, 0, 3);
    run_xfer(1, 2'b00, 2'b01, 16'h4000, 16'h5000, 16'd3, 1, 0, 3);   // R3 src fixed
    run_xfer(1, 2'b11, 2'b10, 16'h4001, 16'h5100, 16'd2, 1, 0, 2);
    run_xfer(1, 2'b01, 2'b01, 16'h6000, 16'h7000, 16'd6, 1, 1, 6);   // R1 start ignored
    run_xfer(0, 2'b01, 2'b01, 16'h8000, 16'h9000, 16'd0, 0, 0, 1);   // R4 wrap, pv=1
    run_xfer(1, 2'b01, 2'b01, 16'h0000, 16'h0000, 16'd0, 0, 0, 65536); // R5 full pass
    finish_run();
  end
endmodule